// File: doc/BRIEF.md
# ADC Input Channel Sequencer

This block decides which analog input pair a single converter channel samples next. It drives a 4-bit positive-input select over sixteen inputs and a 1-bit negative-input select. A 0 on the negative select means the negative reference, and a 1 means input 1. Software loads a full configuration in one write strobe. The analog side pulses `sample_done` once per finished sample/convert sequence, and the sequencer then presents the selection for the following sequence.

Three selection schemes exist. The first uses one fixed pair (set A). The second alternates between set A and set B. The third takes the positive input from an ascending scan of a 16-bit membership mask. Scanning can be combined with alternation: scanned inputs then take the set A slots and interleave with the fixed set B input. A samples-per-interrupt count closes each group of samples with a one-cycle interrupt, and the interrupt restarts both the scan and the alternation at set A.

Top module: `adc_seq`

## Requirements
- R1: After reset `pos_sel` is 0, `neg_sel` is 0 and `intr` is 0.
- R2: With scan and alternate both off, every sample uses `cfg_pos_a` and `cfg_neg_a`.
- R3: With alternate on and scan off, the samples after a restart use set A, then set B (`cfg_pos_b`, `cfg_neg_b`), then A again, and so on.
- R4: With scan on, `cfg_pos_a` has no effect on the output. The positive select in set A slots visits the inputs whose `cfg_mask` bit n is 1, in ascending order of n.
- R5: With scan and alternate both on, samples alternate between the next scanned input and the fixed `cfg_pos_b`.
- R6: Scanning never alters the negative select. Set A slots drive `cfg_neg_a` and set B slots drive `cfg_neg_b`.
- R7: After each interrupt the scan restarts at the lowest set mask bit. Mask inputs beyond the per-interrupt sample count are therefore never selected.
- R8: `intr` is high for exactly the one cycle that follows the `sample_done` completing `cfg_spi` samples. A `cfg_spi` of 0 behaves as 1.
- R9: If the scan passes the highest set mask bit before the interrupt, it wraps to the lowest set bit.
- R10: With scan on and an all-zero mask, set A slots select input 0.
- R11: A configuration write restarts the scan, the phase and the sample count. When it coincides with `sample_done`, the write wins and that strobe is not counted.
- R12: `pos_sel` and `neg_sel` change only in the cycle after a `sample_done` or a configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Loads all cfg_* fields |
| cfg_scan_en | input | 1 | Scan mode enable |
| cfg_alt_en | input | 1 | A/B alternation enable |
| cfg_pos_a | input | 4 | Set A positive input |
| cfg_neg_a | input | 1 | Set A negative input (0 ref, 1 input 1) |
| cfg_pos_b | input | 4 | Set B positive input |
| cfg_neg_b | input | 1 | Set B negative input |
| cfg_mask | input | 16 | Scan membership, bit n = input n |
| cfg_spi | input | 5 | Samples per interrupt, 1..16 (0 acts as 1) |
| sample_done | input | 1 | One sample/convert sequence finished |
| pos_sel | output | 4 | Positive input for the next sample |
| neg_sel | output | 1 | Negative input for the next sample |
| intr | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest case to reach is the interaction of scan wrap-around, A/B interleave and the interrupt restart. In that case the scan pointer has advanced only on set A slots, and it must fall back to the lowest mask bit partway through a pass. The stimulus reaches it with masks and sample counts chosen so that an interrupt lands before, exactly at and after the end of a pass. It adds a configuration write issued in the same cycle as a strobe and an all-zero mask. A behavioural model that walks a list of mask members predicts every output on every clock.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int NUM_IN = 16;
    localparam int SEL_W  = $clog2(NUM_IN);
    localparam int CNT_W  = SEL_W + 1;

    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } phase_e;

    typedef struct packed {
        logic              scan_en;
        logic              alt_en;
        logic [SEL_W-1:0]  pos_a;
        logic              neg_a;
        logic [SEL_W-1:0]  pos_b;
        logic              neg_b;
        logic [NUM_IN-1:0] mask;
        logic [CNT_W-1:0]  spi;
    } cfg_t;

    typedef struct packed {
        phase_e            phase;
        logic [SEL_W-1:0]  start;
        logic [CNT_W-1:0]  cnt;
    } seq_st_t;

    localparam seq_st_t ST_IDLE = '{phase: PH_A, start: '0, cnt: '0};

    function automatic logic [CNT_W-1:0] eff_limit(input logic [CNT_W-1:0] spi);
        return (spi == '0) ? CNT_W'(1) : spi;
    endfunction

    function automatic logic [SEL_W-1:0] lowest_set(input logic [NUM_IN-1:0] v);
        logic [SEL_W-1:0] r;
        r = '0;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (v[i]) r = SEL_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  cfg_t cfg_in,
    output cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)     cfg_q <= '0;
        else if (we) cfg_q <= cfg_in;
    end
endmodule

// File: rtl/adc_seq_scan.sv
module adc_seq_scan
    import adc_seq_pkg::*;
(
    input  logic [NUM_IN-1:0] mask,
    input  logic [SEL_W-1:0]  start,
    output logic [SEL_W-1:0]  pick
);
    logic [NUM_IN-1:0] upper;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_upper
        assign upper[i] = mask[i] && (start <= SEL_W'(i));
    end

    always_comb begin
        if (|upper)     pick = lowest_set(upper);
        else if (|mask) pick = lowest_set(mask);
        else            pick = '0;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             sample_done,
    input  cfg_t             cfg_q,
    input  logic [SEL_W-1:0] scan_pick,
    output seq_st_t          st,
    output logic             intr
);
    logic [CNT_W-1:0] cnt_inc;
    assign cnt_inc = st.cnt + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            intr <= 1'b0;
        end else begin
            intr <= 1'b0;
            if (cfg_we) begin
                st <= ST_IDLE;
            end else if (sample_done) begin
                if (cnt_inc == eff_limit(cfg_q.spi)) begin
                    intr <= 1'b1;
                    st   <= ST_IDLE;
                end else begin
                    st.cnt <= cnt_inc;
                    if (cfg_q.scan_en && st.phase == PH_A)
                        st.start <= scan_pick + SEL_W'(1);
                    if (cfg_q.alt_en)
                        st.phase <= (st.phase == PH_A) ? PH_B : PH_A;
                end
            end
        end
    end

    p_intr_restart_r7: assert property (@(posedge clk) disable iff (rst)
        intr |-> (st.phase == PH_A && st.start == '0 && st.cnt == '0));

    p_cfg_restart_r11: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_we) |-> (st.cnt == '0 && st.phase == PH_A && !intr));
endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_scan_en,
    input  logic              cfg_alt_en,
    input  logic [SEL_W-1:0]  cfg_pos_a,
    input  logic              cfg_neg_a,
    input  logic [SEL_W-1:0]  cfg_pos_b,
    input  logic              cfg_neg_b,
    input  logic [NUM_IN-1:0] cfg_mask,
    input  logic [CNT_W-1:0]  cfg_spi,
    input  logic              sample_done,
    output logic [SEL_W-1:0]  pos_sel,
    output logic              neg_sel,
    output logic              intr
);
    cfg_t             cfg_in, cfg_q;
    seq_st_t          st;
    logic [SEL_W-1:0] scan_pick;

    always_comb begin
        cfg_in.scan_en = cfg_scan_en;
        cfg_in.alt_en  = cfg_alt_en;
        cfg_in.pos_a   = cfg_pos_a;
        cfg_in.neg_a   = cfg_neg_a;
        cfg_in.pos_b   = cfg_pos_b;
        cfg_in.neg_b   = cfg_neg_b;
        cfg_in.mask    = cfg_mask;
        cfg_in.spi     = cfg_spi;
    end

    adc_seq_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .cfg_in(cfg_in),
        .cfg_q (cfg_q)
    );

    adc_seq_scan u_scan (
        .mask (cfg_q.mask),
        .start(st.start),
        .pick (scan_pick)
    );

    adc_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .sample_done(sample_done),
        .cfg_q      (cfg_q),
        .scan_pick  (scan_pick),
        .st         (st),
        .intr       (intr)
    );

    always_comb begin
        if (st.phase == PH_B) begin
            pos_sel = cfg_q.pos_b;
            neg_sel = cfg_q.neg_b;
        end else begin
            pos_sel = cfg_q.scan_en ? scan_pick : cfg_q.pos_a;
            neg_sel = cfg_q.neg_a;
        end
    end

    p_sel_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!$past(sample_done) && !$past(cfg_we)) |-> ($stable(pos_sel) && $stable(neg_sel)));

    p_intr_cause_r8: assert property (@(posedge clk) disable iff (rst)
        intr |-> ($past(sample_done) && !$past(cfg_we)));

    p_scan_member_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.scan_en && (|cfg_q.mask) && st.phase == PH_A) |-> cfg_q.mask[pos_sel]);

    p_empty_mask_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.scan_en && cfg_q.mask == '0 && st.phase == PH_A) |-> pos_sel == '0);

    p_fixed_pair_r2: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.scan_en && !cfg_q.alt_en) |-> (pos_sel == cfg_q.pos_a && neg_sel == cfg_q.neg_a));
endmodule

// File: tb/adc_seq_test.sv
module adc_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_scan_en = 1'b0;
    logic        cfg_alt_en = 1'b0;
    logic [3:0]  cfg_pos_a = '0;
    logic        cfg_neg_a = 1'b0;
    logic [3:0]  cfg_pos_b = '0;
    logic        cfg_neg_b = 1'b0;
    logic [15:0] cfg_mask = '0;
    logic [4:0]  cfg_spi = '0;
    logic        sample_done = 1'b0;
    logic [3:0]  pos_sel;
    logic        neg_sel;
    logic        intr;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    bit live = 0;

    // behavioural model state
    int m_scan, m_alt, m_pa, m_na, m_pb, m_nb, m_spi;
    int m_mask;
    int m_ph, m_k, m_cnt, m_intr;
    int seen [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_scan_en(cfg_scan_en),
        .cfg_alt_en(cfg_alt_en), .cfg_pos_a(cfg_pos_a), .cfg_neg_a(cfg_neg_a),
        .cfg_pos_b(cfg_pos_b), .cfg_neg_b(cfg_neg_b), .cfg_mask(cfg_mask),
        .cfg_spi(cfg_spi), .sample_done(sample_done),
        .pos_sel(pos_sel), .neg_sel(neg_sel), .intr(intr)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_pos();
        int lst[$];
        if (m_ph == 1) return m_pb;
        if (!m_scan) return m_pa;
        for (int i = 0; i < 16; i++) if (m_mask[i]) lst.push_back(i);
        if (lst.size() == 0) return 0;
        return lst[m_k % lst.size()];
    endfunction

    function automatic string mode_tag();
        if (m_scan && m_alt) return "R5";
        if (m_scan) return (m_mask == 0) ? "R10" : "R4/R9";
        if (m_alt) return "R3";
        return "R2";
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_scan = 0; m_alt = 0; m_pa = 0; m_na = 0; m_pb = 0; m_nb = 0;
            m_spi = 0; m_mask = 0; m_ph = 0; m_k = 0; m_cnt = 0; m_intr = 0;
        end else begin
            m_intr = 0;
            if (cfg_we) begin
                m_scan = cfg_scan_en; m_alt = cfg_alt_en; m_pa = cfg_pos_a;
                m_na = cfg_neg_a; m_pb = cfg_pos_b; m_nb = cfg_neg_b;
                m_mask = cfg_mask; m_spi = cfg_spi;
                m_ph = 0; m_k = 0; m_cnt = 0;
            end else if (sample_done) begin
                m_cnt++;
                if (m_cnt == ((m_spi == 0) ? 1 : m_spi)) begin
                    m_intr = 1; m_cnt = 0; m_ph = 0; m_k = 0;
                end else begin
                    if (m_scan && m_ph == 0) m_k++;
                    if (m_alt) m_ph = 1 - m_ph;
                end
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (live && !rst) begin
            check(pos_sel == exp_pos(), mode_tag(), pos_sel, exp_pos());
            check(neg_sel == ((m_ph == 1) ? m_nb : m_na), "R6", neg_sel,
                  (m_ph == 1) ? m_nb : m_na);
            check(intr == m_intr, "R8", intr, m_intr);
        end
    end

    task automatic configure(input bit sc, input bit al, input int pa, input int na,
                             input int pb, input int nb, input int mask, input int spi);
        @(negedge clk);
        cfg_scan_en = sc; cfg_alt_en = al; cfg_pos_a = 4'(pa); cfg_neg_a = 1'(na);
        cfg_pos_b = 4'(pb); cfg_neg_b = 1'(nb); cfg_mask = 16'(mask); cfg_spi = 5'(spi);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic strobes(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            seen[pos_sel]++;
            sample_done = 1'b1;
            @(negedge clk);
            sample_done = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(pos_sel == 0 && neg_sel == 0 && intr == 0, "R1", {pos_sel, neg_sel, intr}, 0);
        live = 1;

        // R2: fixed pair
        configure(0, 0, 7, 1, 2, 0, 16'hFFFF, 4);
        check(pos_sel == 7 && neg_sel == 1, "R2", pos_sel, 7);
        strobes(9, 1);

        // R3: alternation with back-to-back strobes
        configure(0, 1, 3, 0, 12, 1, 0, 5);
        strobes(12, 0);
        strobes(3, 2);

        // R4, R9: scan ascending with wrap, pos_a ignored
        configure(1, 0, 9, 1, 0, 0, 16'h8425, 16);
        check(pos_sel == 0, "R4", pos_sel, 0);
        strobes(12, 1);

        // R5, R6: scan interleaved with fixed set B
        configure(1, 1, 0, 1, 14, 0, 16'h0152, 7);
        strobes(16, 0);

        // R7: mask wider than samples per interrupt
        for (int i = 0; i < 16; i++) seen[i] = 0;
        configure(1, 0, 0, 0, 0, 0, 16'h2224, 3);
        strobes(12, 1);
        check(seen[13] == 0, "R7", seen[13], 0);
        check(seen[2] == 4, "R7", seen[2], 4);

        // R10: empty scan mask
        configure(1, 0, 5, 0, 0, 0, 0, 4);
        check(pos_sel == 0, "R10", pos_sel, 0);
        strobes(5, 0);

        // R8: count of 0 interrupts on every strobe
        configure(0, 1, 4, 0, 8, 1, 0, 0);
        strobes(4, 1);

        // R11: config write mid-sequence and coinciding with a strobe
        configure(1, 1, 0, 0, 11, 1, 16'h00F0, 9);
        strobes(3, 0);
        @(negedge clk);
        cfg_we = 1'b1; sample_done = 1'b1; cfg_spi = 5'd2;
        @(negedge clk);
        cfg_we = 1'b0; sample_done = 1'b0;
        check(pos_sel == 4 && intr == 0, "R11", pos_sel, 4);
        strobes(1, 0);
        check(pos_sel == 11, "R11", pos_sel, 11);
        strobes(1, 0);
        check(pos_sel == 4, "R11", pos_sel, 4);

        // R12: idle cycles leave the selection unchanged
        strobes(1, 0);
        begin
            automatic int held = pos_sel;
            repeat (6) @(negedge clk);
            check(pos_sel == held, "R12", pos_sel, held);
        end

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule